// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides one unsigned operand by another over several clock cycles and returns both the quotient and the remainder. Both operands are 32 bits wide by default. A single double-width working register carries the whole computation. Its upper half grows into the partial remainder. Its lower half starts as the dividend and fills up with quotient bits from the right, one new bit entering the vacated least significant position on every step. Each step shifts the register left by one place. It then compares the upper half, extended by the bit shifted out of it, against the divisor. When the extended value is not smaller, it subtracts the divisor and sets the new quotient bit.

A caller raises `start` for one cycle with the operands. `busy` going low is the readiness signal: an operand pair is taken only on a clock edge where `start` is high and `busy` is low. A `start` seen while `busy` is high is dropped, and the caller must hold its request and try again. The result side has no back-pressure. `done` pulses for exactly one cycle, and the outputs then keep their values until the next accepted start. The `STEPS` parameter sets how many shift-compare-subtract steps run per clock. `STEPS` = 1 gives 32 cycles and `STEPS` = 2 gives 16 cycles, for the same results. `WIDTH` must be a multiple of `STEPS`.

Top module: `divider_seq`

## Requirements
- R1: While reset is asserted and afterwards until the first accepted start, `busy` and `done` are 0 and `quotient` and `remainder` are 0.
- R2: A start is accepted on a clock edge where `start` is 1 and `busy` is 0. From that edge `busy` is 1 for exactly WIDTH/STEPS cycles (32 with the default parameters).
- R3: `done` is 1 for exactly one cycle. It rises on the same edge on which `busy` falls, WIDTH/STEPS edges after the accepting edge.
- R4: For a nonzero divisor, when `done` is 1, `quotient` equals the dividend divided by the divisor, rounded down, and `remainder` equals the dividend modulo the divisor.
- R5: R4 also holds when the divisor has its most significant bit set and the partial remainder is wider than WIDTH bits after the shift.
- R6: A divisor of zero raises no error. The result has `quotient` with every bit 1 and `remainder` equal to the dividend.
- R7: A start seen while `busy` is 1 is ignored. The running division finishes on its original schedule with its original operands.
- R8: After `done`, `quotient` and `remainder` hold their values until the next accepted start, whatever the operand inputs do.
- R9: With `STEPS` = 2, each clock applies two steps in sequence. The division finishes in 16 cycles and gives the same results as with `STEPS` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a division with the present operands |
| dividend | input | WIDTH | Value to be divided, sampled when a start is accepted |
| divisor | input | WIDTH | Value to divide by, sampled when a start is accepted |
| busy | output | 1 | A division is running; a low level means a start will be taken |
| done | output | 1 | One-cycle pulse when the result is ready |
| quotient | output | WIDTH | Lower half of the working register; the quotient after done |
| remainder | output | WIDTH | Upper half of the working register; the remainder after done |

## Verification
A bad step count shows up as `done` arriving early or late, and the per-clock model flags it on the very cycle it would have expected the pulse. A wrong compare or subtract in any step leaves a bad quotient bit or remainder that cannot be corrected later. That error is visible at the ports on the cycle `done` rises. Divisors with the top bit set are included because a compare that drops the shifted-out bit fails only on those. A captured divisor that gets overwritten while `busy` is high shows up as a wrong result for the first operand pair.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic { ST_IDLE = 1'b0, ST_RUN = 1'b1 } div_state_e;
endpackage

// File: rtl/div_step.sv
module div_step #(
  parameter int WIDTH = 32
) (
  input  logic [2*WIDTH-1:0] work_i,
  input  logic [WIDTH-1:0]   dvs_i,
  output logic [2*WIDTH-1:0] work_o
);
  localparam int DW = 2 * WIDTH;

  logic [DW-1:0]  shifted;
  logic           spill;
  logic [WIDTH:0] upper_ext;
  logic [WIDTH:0] diff;
  logic           take;

  always_comb begin
    spill     = work_i[DW-1];
    shifted   = {work_i[DW-2:0], 1'b0};
    upper_ext = {spill, shifted[DW-1:WIDTH]};
    diff      = upper_ext - {1'b0, dvs_i};
    take      = (upper_ext >= {1'b0, dvs_i});
    if (take) begin
      work_o = {diff[WIDTH-1:0], shifted[WIDTH-1:1], 1'b1};
    end else begin
      work_o = shifted;
    end
  end
endmodule

// File: rtl/div_count.sv
module div_count #(
  parameter int ITER = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic en,
  output logic last
);
  localparam int CW = $clog2(ITER + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CW'(ITER);
    end else if (en && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == CW'(1));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(ITER)); // R2
  AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |-> cnt_q != '0); // R3
endmodule

// File: rtl/divider_seq.sv
module divider_seq #(
  parameter int WIDTH = 32,
  parameter int STEPS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  import div_pkg::*;

  localparam int DW   = 2 * WIDTH;
  localparam int ITER = WIDTH / STEPS;

  div_state_e     state_q;
  logic [DW-1:0]  work_q;
  logic [WIDTH-1:0] dvs_q;
  logic           done_q;
  logic           accept;
  logic           running;
  logic           last;
  logic [DW-1:0]  stage [STEPS+1];

  assign running = (state_q == ST_RUN);
  assign accept  = start && !running;

  assign stage[0] = work_q;
  for (genvar g = 0; g < STEPS; g++) begin : g_step
    div_step #(.WIDTH(WIDTH)) u_step (
      .work_i(stage[g]),
      .dvs_i (dvs_q),
      .work_o(stage[g+1])
    );
  end

  div_count #(.ITER(ITER)) u_count (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept),
    .en   (running),
    .last (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      work_q  <= '0;
      dvs_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= ST_RUN;
        work_q  <= {{WIDTH{1'b0}}, dividend};
        dvs_q   <= divisor;
      end else if (running) begin
        work_q <= stage[STEPS];
        if (last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign busy      = running;
  assign done      = done_q;
  assign quotient  = work_q[WIDTH-1:0];
  assign remainder = work_q[DW-1:WIDTH];

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(dvs_q)); // R7
  AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dvs_q != '0) |-> remainder < dvs_q); // R4
  AST_ZERO_DIV_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dvs_q == '0) |-> quotient == '1); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder))); // R8
endmodule

// File: tb/test_divider_seq.sv
module test_divider_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy_w [2];
  logic        done_w [2];
  logic [31:0] q_w [2];
  logic [31:0] r_w [2];

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string cur_tag = "R1";

  bit          m_busy [2];
  bit          m_done [2];
  int          m_cnt [2];
  logic [31:0] m_q [2];
  logic [31:0] m_r [2];
  logic [31:0] p_q [2];
  logic [31:0] p_r [2];

  always #10 clk = ~clk;

  divider_seq #(.WIDTH(32), .STEPS(1)) i_divider_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy_w[0]), .done(done_w[0]), .quotient(q_w[0]), .remainder(r_w[0]));

  divider_seq #(.WIDTH(32), .STEPS(2)) i_divider_seq_x2 (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy_w[1]), .done(done_w[1]), .quotient(q_w[1]), .remainder(r_w[1]));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // behavioural reference, one copy per configuration
  always @(posedge clk or negedge rst_n) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        m_busy[k] = 0; m_done[k] = 0; m_cnt[k] = 0; m_q[k] = 0; m_r[k] = 0;
      end else begin
        m_done[k] = 0;
        if (!m_busy[k] && start) begin
          m_busy[k] = 1;
          m_cnt[k] = (k == 0) ? 32 : 16;
          if (divisor == 0) begin
            p_q[k] = 32'hFFFF_FFFF; p_r[k] = dividend;
          end else begin
            p_q[k] = dividend / divisor; p_r[k] = dividend % divisor;
          end
        end else if (m_busy[k]) begin
          m_cnt[k]--;
          if (m_cnt[k] == 0) begin
            m_busy[k] = 0; m_done[k] = 1; m_q[k] = p_q[k]; m_r[k] = p_r[k];
          end
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 2; k++) begin
        chk(busy_w[k] == m_busy[k], (k == 0) ? "R2 busy" : "R9 busy", 64'(busy_w[k]), 64'(m_busy[k]));
        chk(done_w[k] == m_done[k], (k == 0) ? "R3 done" : "R9 done", 64'(done_w[k]), 64'(m_done[k]));
        if (!m_busy[k]) begin
          chk(q_w[k] == m_q[k], {cur_tag, " quotient"}, 64'(q_w[k]), 64'(m_q[k]));
          chk(r_w[k] == m_r[k], {cur_tag, " remainder"}, 64'(r_w[k]), 64'(m_r[k]));
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic run_div(input logic [31:0] a, input logic [31:0] b, input string tag, input bit poke);
    @(negedge clk);
    cur_tag = tag;
    start = 1'b1; dividend = a; divisor = b;
    @(negedge clk);
    start = 1'b0; dividend = ~a; divisor = b ^ 32'h5A5A_0001;
    if (poke) begin
      repeat (4) @(negedge clk);
      cur_tag = "R7";
      start = 1'b1; dividend = 32'd999; divisor = 32'd3;
      @(negedge clk);
      start = 1'b0;
    end
    while (m_busy[0] || m_busy[1]) @(negedge clk);
    // R8: outputs hold while inputs wander and start stays low
    dividend = 32'h1234_5678; divisor = 32'd7;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] seed;
    seed = 32'hC0FF_EE11;
    repeat (2) @(negedge clk);
    // R1: reset state observed while reset is held
    for (int k = 0; k < 2; k++) begin
      chk(busy_w[k] == 0 && done_w[k] == 0, "R1 flags", {busy_w[k], done_w[k]}, 0);
      chk(q_w[k] == 0 && r_w[k] == 0, "R1 data", {q_w[k], r_w[k]}, 0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_div(32'd100, 32'd7, "R4", 0);
    run_div(32'd65538, 32'd128, "R4", 0);
    run_div(32'd0, 32'd5, "R4", 0);
    run_div(32'd12345, 32'd123456, "R4", 0);
    run_div(32'hFFFF_FFFF, 32'd1, "R4", 0);
    run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5", 0);
    run_div(32'hFFFF_FFFE, 32'h8000_0000, "R5", 0);
    run_div(32'h8000_0000, 32'h8000_0001, "R5", 0);
    run_div(32'hF000_0001, 32'h9000_0000, "R5", 0);
    run_div(32'd5, 32'd0, "R6", 0);
    run_div(32'hDEAD_BEEF, 32'd0, "R6", 0);
    run_div(32'd1000, 32'd10, "R7", 1);
    run_div(32'hABCD_0123, 32'h0000_0F0F, "R7", 1);
    for (int n = 0; n < 16; n++) begin
      logic [31:0] a;
      logic [31:0] b;
      seed = seed * 32'd1664525 + 32'd1013904223; a = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; b = seed >> (seed[4:0]);
      run_div(a, b, "R9", 0);
    end
    finish_run();
  end
endmodule